// File: doc/BRIEF.md
# 64-bit Global Timer with Comparator

The block is a free-running 64-bit up-counter with a programmable clock divider and a single 64-bit compare register, all reached over a plain 32-bit register bus (address, write strobe, write data, combinational read data). Software starts the counter, loads a compare value, and receives an event flag plus an optional level interrupt once the count has reached or passed that value.

For periodic ticks a 32-bit step register is added to the compare value on every match, so the next event is re-armed in hardware. Without the step enable the block behaves as a one-shot: the flag stays set and the compare value is left untouched until software reloads it. The 64-bit counter is read as two words; a carry between the two reads is caught by reading the upper word, then the lower word, then the upper word again.

Top module: `glb_timer64`

## Requirements
- R1: After reset every register reads zero and `irq` is low, so the timer is stopped and the divider ratio is one.
- R2: While the run bit is set the counter rises by exactly one every (divider + 1) clock cycles; while the run bit is clear it holds its value.
- R3: The counter is read at word offsets 0x00 (bits 31:0) and 0x04 (bits 63:32); writes to those offsets load the matching half only while the run bit is clear and are ignored while it is set.
- R4: On every counter tick with the compare enable set, the flag (status bit 0, offset 0x0C) is set when the counter value held at that tick is greater than or equal to the 64-bit compare value (low word 0x10, high word 0x14).
- R5: While the compare enable is clear the flag is never set, including by writes to the compare words.
- R6: Writing status with bit 0 = 1 clears the flag; writing bit 0 = 0 leaves it unchanged; a match in the same cycle wins over the clear.
- R7: With the step enable set, each match adds the 32-bit step value (offset 0x18, zero-extended) to the compare value, so the compare value tracks the counter in steps of that size.
- R8: With the step enable clear, a match leaves the compare value unchanged.
- R9: `irq` is high exactly while the flag and the interrupt enable are both set.
- R10: The control word at 0x08 holds run in bit 0, compare enable in bit 1, interrupt enable in bit 2, step enable in bit 3 and the 8-bit divider in bits 15:8; all other bits read zero. The step register reads back what was written.
- R11: A carry out of the lower counter word appears in the upper word, so an upper-word read before and after the carry differs by one while the lower word has wrapped to a small value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is the upper-word carry, since from reset it would take four billion ticks; the stimulus stops the timer, preloads the lower word a few counts below its wrap point, restarts, and reads the upper word on each side of the carry. Periodic re-arming is hard to pin down from a single read because the compare value chases a moving counter, so a behavioural model in the bench mirrors the register state every cycle and the bench compares the read port and `irq` against it while directed checks test the relation between the compare value and the counter.

// File: rtl/glb_timer64.sv
module glb_timer64 #(
  parameter int ADDR_W  = 5,
  parameter int PRESC_W = 8,
  parameter int INC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFF_CLO = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_CHI = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_CTL = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFF_STS = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFF_MLO = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFF_MHI = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] OFF_INC = ADDR_W'(8'h18);

  logic               run, cmp_on, irq_on, reload_on, evt;
  logic [PRESC_W-1:0] psc, div;
  logic [63:0]        count, match_val;
  logic [INC_W-1:0]   step;
  logic               tick, hit;

  assign tick = run && (div == psc);
  assign hit  = tick && cmp_on && (count >= match_val);
  assign irq  = evt && irq_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div <= '0;
    else if (!run || tick) div <= '0;
    else div <= div + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (bus_we && !run && bus_addr == OFF_CLO) count[31:0] <= bus_wdata;
    else if (bus_we && !run && bus_addr == OFF_CHI) count[63:32] <= bus_wdata;
    else if (tick) count <= count + 64'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_val <= '0;
    else if (bus_we && bus_addr == OFF_MLO) match_val[31:0] <= bus_wdata;
    else if (bus_we && bus_addr == OFF_MHI) match_val[63:32] <= bus_wdata;
    else if (hit && reload_on) match_val <= match_val + 64'(step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt <= 1'b0;
    else if (hit) evt <= 1'b1;
    else if (bus_we && bus_addr == OFF_STS && bus_wdata[0]) evt <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; cmp_on <= 1'b0; irq_on <= 1'b0; reload_on <= 1'b0;
      psc <= '0; step <= '0;
    end else if (bus_we) begin
      if (bus_addr == OFF_CTL) begin
        run       <= bus_wdata[0];
        cmp_on    <= bus_wdata[1];
        irq_on    <= bus_wdata[2];
        reload_on <= bus_wdata[3];
        psc       <= bus_wdata[8 +: PRESC_W];
      end
      if (bus_addr == OFF_INC) step <= bus_wdata[INC_W-1:0];
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_CLO: bus_rdata = count[31:0];
      OFF_CHI: bus_rdata = count[63:32];
      OFF_CTL: bus_rdata = 32'({psc, 4'b0000, reload_on, irq_on, cmp_on, run});
      OFF_STS: bus_rdata = {31'd0, evt};
      OFF_MLO: bus_rdata = match_val[31:0];
      OFF_MHI: bus_rdata = match_val[63:32];
      OFF_INC: bus_rdata = 32'(step);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/glb_timer64_chk.sv
module glb_timer64_chk #(
  parameter int ADDR_W  = 5,
  parameter int PRESC_W = 8,
  parameter int INC_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_we,
  input logic [31:0]        bus_wdata,
  input logic               irq,
  input logic               run,
  input logic               cmp_on,
  input logic               irq_on,
  input logic               reload_on,
  input logic               evt,
  input logic [PRESC_W-1:0] psc,
  input logic [PRESC_W-1:0] div,
  input logic [63:0]        count,
  input logic [63:0]        match_val,
  input logic [INC_W-1:0]   step
);
  logic cwr, mwr, swr;
  assign cwr = bus_we && (bus_addr == ADDR_W'(8'h00) || bus_addr == ADDR_W'(8'h04));
  assign mwr = bus_we && (bus_addr == ADDR_W'(8'h10) || bus_addr == ADDR_W'(8'h14));
  assign swr = bus_we && (bus_addr == ADDR_W'(8'h0C));

  p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cwr) |=> $stable(count));
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cwr |=> (count == $past(count) || count == $past(count) + 64'd1));
  p_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cwr && run) |=> (count - $past(count) <= 64'd1));
  p_ge_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cmp_on && div == psc && count >= match_val) |=> evt);
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_on && !evt) |=> !evt);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (swr && bus_wdata[0] && !cmp_on) |=> !evt);
  p_zero_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (swr && !bus_wdata[0] && evt) |=> evt);
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mwr |=> (match_val == $past(match_val) ||
              match_val == $past(match_val) + 64'($past(step))));
  p_oneshot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload_on && !mwr) |=> $stable(match_val));
  p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> evt);
  p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_on |-> !irq);
endmodule

bind glb_timer64 glb_timer64_chk #(.ADDR_W(ADDR_W), .PRESC_W(PRESC_W), .INC_W(INC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .irq(irq), .run(run), .cmp_on(cmp_on), .irq_on(irq_on), .reload_on(reload_on),
  .evt(evt), .psc(psc), .div(div), .count(count), .match_val(match_val), .step(step)
);

// File: tb/glb_timer64_tb_top.sv
`timescale 1ns/1ps
module glb_timer64_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  glb_timer64 dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
                     .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  // behavioural reference state
  logic [63:0] m_cnt = '0, m_cmp = '0;
  logic [31:0] m_inc = '0;
  logic [7:0]  m_psc = '0, m_div = '0;
  bit m_run = 0, m_ce = 0, m_ie = 0, m_ae = 0, m_flag = 0;

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return m_cnt[31:0];
      5'h04: return m_cnt[63:32];
      5'h08: return {16'd0, m_psc, 4'd0, m_ae, m_ie, m_ce, m_run};
      5'h0C: return {31'd0, m_flag};
      5'h10: return m_cmp[31:0];
      5'h14: return m_cmp[63:32];
      5'h18: return m_inc;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    case (a)
      5'h00, 5'h04: return "R3";
      5'h08, 5'h18: return "R10";
      5'h0C: return "R6";
      5'h10, 5'h14: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_cmp = '0; m_inc = '0; m_psc = '0; m_div = '0;
      m_run = 0; m_ce = 0; m_ie = 0; m_ae = 0; m_flag = 0;
    end else begin
      bit tk, mt;
      logic [63:0] nc, nm;
      tk = m_run && (m_div == m_psc);
      mt = tk && m_ce && (m_cnt >= m_cmp);
      nc = m_cnt;
      if (bus_we && !m_run && bus_addr == 5'h00) nc[31:0] = bus_wdata;
      else if (bus_we && !m_run && bus_addr == 5'h04) nc[63:32] = bus_wdata;
      else if (tk) nc = m_cnt + 1;
      nm = m_cmp;
      if (bus_we && bus_addr == 5'h10) nm[31:0] = bus_wdata;
      else if (bus_we && bus_addr == 5'h14) nm[63:32] = bus_wdata;
      else if (mt && m_ae) nm = m_cmp + {32'd0, m_inc};
      if (mt) m_flag = 1;
      else if (bus_we && bus_addr == 5'h0C && bus_wdata[0]) m_flag = 0;
      m_div = (!m_run || tk) ? 8'd0 : m_div + 8'd1;
      if (bus_we && bus_addr == 5'h08) begin
        m_run = bus_wdata[0]; m_ce = bus_wdata[1]; m_ie = bus_wdata[2];
        m_ae = bus_wdata[3]; m_psc = bus_wdata[15:8];
      end
      if (bus_we && bus_addr == 5'h18) m_inc = bus_wdata;
      m_cnt = nc; m_cmp = nm;
    end
    #1;
    if (rst_n && !done) begin
      check(tag_of(bus_addr), {32'd0, bus_rdata}, {32'd0, m_read(bus_addr)});
      check("R9", {63'd0, irq}, {63'd0, m_flag && m_ie});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] v, a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int k = 0; k < 7; k++) begin
      rd(5'(4 * k), v);
      check("R1", {32'd0, v}, 64'd0);
    end
    check("R1", {63'd0, irq}, 64'd0);

    // R10 control layout and step register
    wr(5'h08, 32'hFFFF_FFF0); rd(5'h08, v); check("R10", {32'd0, v}, 64'h0000_FF00);
    wr(5'h18, 32'hCAFE_0001); rd(5'h18, v); check("R10", {32'd0, v}, 64'hCAFE_0001);
    wr(5'h08, 32'h0);

    // R3 counter load while stopped, ignored while running
    wr(5'h00, 32'h1234_5678); wr(5'h04, 32'h0000_0009);
    rd(5'h00, v); check("R3", {32'd0, v}, 64'h1234_5678);
    rd(5'h04, v); check("R3", {32'd0, v}, 64'h9);
    wr(5'h08, 32'h1);
    wr(5'h00, 32'h0); wr(5'h04, 32'h0);
    rd(5'h04, v); check("R3", {32'd0, v}, 64'h9);
    rd(5'h00, v); check("R3", {63'd0, (v > 32'h1234_5678) && (v < 32'h1234_5700)}, 64'd1);

    // R2 divider ratio 4 and hold while stopped
    wr(5'h08, 32'h0); wr(5'h00, 32'h0); wr(5'h08, 32'h0301);
    rd(5'h00, a); repeat (39) @(negedge clk); rd(5'h00, b);
    check("R2", {32'd0, b - a}, 64'd10);
    wr(5'h08, 32'h0300);
    rd(5'h00, a); repeat (19) @(negedge clk); rd(5'h00, b);
    check("R2", {32'd0, b}, {32'd0, a});

    // R11 carry into the upper word
    wr(5'h08, 32'h0); wr(5'h00, 32'hFFFF_FFFA); wr(5'h04, 32'h0); wr(5'h08, 32'h1);
    rd(5'h04, v); check("R11", {32'd0, v}, 64'd0);
    repeat (10) @(negedge clk);
    rd(5'h04, v); check("R11", {32'd0, v}, 64'd1);
    rd(5'h00, v); check("R11", {63'd0, v < 32'd32}, 64'd1);

    // R5 no flag with compare disabled, R4 greater-or-equal match
    wr(5'h08, 32'h0); wr(5'h0C, 32'h1);
    wr(5'h00, 32'd100); wr(5'h04, 32'h0);
    wr(5'h10, 32'd50); wr(5'h14, 32'h0);
    rd(5'h0C, v); check("R5", {32'd0, v}, 64'd0);
    wr(5'h08, 32'h1); repeat (10) @(negedge clk);
    rd(5'h0C, v); check("R5", {32'd0, v}, 64'd0);
    wr(5'h08, 32'h3); repeat (3) @(negedge clk);
    rd(5'h0C, v); check("R4", {32'd0, v}, 64'd1);
    check("R9", {63'd0, irq}, 64'd0);
    wr(5'h08, 32'h7); @(negedge clk); #1;
    check("R9", {63'd0, irq}, 64'd1);

    // R6 write-one-to-clear
    wr(5'h08, 32'h5);
    wr(5'h0C, 32'h0); rd(5'h0C, v); check("R6", {32'd0, v}, 64'd1);
    wr(5'h0C, 32'h1); rd(5'h0C, v); check("R6", {32'd0, v}, 64'd0);
    check("R9", {63'd0, irq}, 64'd0);

    // R8 one-shot: equality reached, compare value kept
    wr(5'h08, 32'h0); wr(5'h00, 32'h0); wr(5'h04, 32'h0); wr(5'h10, 32'd20);
    wr(5'h08, 32'h3); repeat (40) @(negedge clk);
    rd(5'h0C, v); check("R4", {32'd0, v}, 64'd1);
    rd(5'h10, v); check("R8", {32'd0, v}, 64'd20);
    rd(5'h14, v); check("R8", {32'd0, v}, 64'd0);

    // R7 periodic re-arm by step 16
    wr(5'h08, 32'h0); wr(5'h0C, 32'h1); wr(5'h00, 32'h0);
    wr(5'h10, 32'd10); wr(5'h18, 32'd16); wr(5'h08, 32'hF);
    repeat (100) @(negedge clk);
    rd(5'h00, a); rd(5'h10, b);
    check("R7", {63'd0, (b >= a) && (b - a <= 32'd17)}, 64'd1);
    check("R7", {32'd0, (b - 32'd10) % 32'd16}, 64'd0);
    check("R7", {63'd0, b > 32'd90}, 64'd1);
    check("R9", {63'd0, irq}, 64'd1);

    repeat (4) @(negedge clk);
    done = 1;
    summary();
  end
endmodule